// File: doc/BRIEF.md
# Isochronous Cycle Timer

This block keeps the isochronous cycle time of a serial bus link layer. A fast link clock is halved into a counting tick. A sub-cycle offset runs on that tick and wraps into a cycle count, and the cycle count wraps into a seconds field. The block derives an 8 kHz cycle clock from the offset. It emits a one-cycle boundary event each time a new cycle begins.

On the cycle-master node, every cycle boundary also raises a one-cycle request to transmit a cycle-start packet. On any other node, the timestamp carried by each received cycle-start packet is loaded straight into the timer, which keeps the node aligned to the bus master. A mode input can take the cycle boundary from an external cycle input pin instead of the internal offset wrap. That pin is first synchronized to the link clock.

Top module: `cyc_timer`

## Requirements
- R1: While rst_ni is low, timer_o is zero and boundary_o and start_req_o are low.
- R2: When enabled with ext_sel_i low, the offset advances by one on every second link clock. It counts from 0 to 3071, then returns to 0 and advances the cycle count. The edge where it returns to 0 raises boundary_o for exactly one clock.
- R3: The cycle count returns from 7999 to 0 and advances the seconds field at the same edge. The seconds field returns from 127 to 0.
- R4: timer_o carries seconds in bits 31:25, cycle count in bits 24:12 and offset in bits 11:0. rx_stamp_i uses the same layout.
- R5: While enable_i is low, timer_o holds its value, boundary_o and start_req_o stay low, and rx_valid_i is ignored.
- R6: With enable_i high and master_i low, rx_valid_i loads rx_stamp_i into the timer at the next edge. The load overrides any increment at that edge. It raises boundary_o only if the loaded cycle count differs from the current one.
- R7: With master_i high, start_req_o pulses for one clock together with each boundary_o and rx_valid_i is ignored. With master_i low, start_req_o stays low.
- R8: With ext_sel_i high, a rising edge on cyc_ext_i passes two synchronizer flops. At the third link clock edge after the edge it sets the offset to 0, advances the cycle count and raises boundary_o. In this mode the offset stops at 3071 instead of wrapping.
- R9: cycle_clk_o is high while the offset is below 1536 and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock (nominally 49.152 MHz) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Timer run enable |
| master_i | input | 1 | Node is cycle master |
| ext_sel_i | input | 1 | Take cycle boundaries from cyc_ext_i |
| cyc_ext_i | input | 1 | External cycle clock, asynchronous |
| rx_valid_i | input | 1 | Received cycle-start timestamp strobe |
| rx_stamp_i | input | 32 | Received timestamp |
| timer_o | output | 32 | Current cycle time |
| cycle_clk_o | output | 1 | Cycle clock |
| start_req_o | output | 1 | Cycle-start transmit request pulse |
| boundary_o | output | 1 | Cycle boundary pulse |

## Verification
Several rules are checked on every cycle:
- the offset range;
- the offset reading zero on every boundary that is not caused by a timestamp load;
- the timer holding while disabled;
- an exact load of the strobed timestamp;
- requests appearing only alongside boundaries in master mode.

The following can only be shown by the bench's directed scenarios:
- the cycle and seconds carries;
- the suppression of boundaries on a load into the same cycle;
- the synchronizer latency and offset saturation in external mode;
- the cycle clock duty.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  localparam int OFF_W  = 12;
  localparam int CYC_W  = 13;
  localparam int SEC_W  = 7;
  localparam int TIME_W = SEC_W + CYC_W + OFF_W;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CYC_W-1:0] cyc;
    logic [OFF_W-1:0] off;
  } cyc_time_t;
endpackage

// File: rtl/cyc_tick_div.sv
module cyc_tick_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= 1'b0;
    else if (en_i)  phase_q <= ~phase_q;
    else            phase_q <= 1'b0;
  end

  assign tick_o = phase_q;
endmodule

// File: rtl/cyc_edge_sync.sv
module cyc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic rise_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], din_i};
  end

  // sync_q[STAGES-1] is the synchronized level, sync_q[STAGES] its previous value
  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/cyc_count_chain.sv
module cyc_count_chain
  import cyc_timer_pkg::*;
#(
  parameter int OFF_LAST = 3071,
  parameter int CYC_LAST = 7999
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      tick_i,
  input  logic      ext_sel_i,
  input  logic      ext_rise_i,
  input  logic      master_i,
  input  logic      load_i,
  input  cyc_time_t stamp_i,
  output cyc_time_t time_o,
  output logic      bnd_o,
  output logic      req_o
);
  localparam logic [OFF_W-1:0] OffLast = OFF_W'(OFF_LAST);
  localparam logic [CYC_W-1:0] CycLast = CYC_W'(CYC_LAST);

  cyc_time_t cur_q, nxt;
  logic      bnd_d, bnd_q, req_q;

  function automatic cyc_time_t next_cycle(cyc_time_t t);
    cyc_time_t r;
    r     = t;
    r.off = '0;
    if (t.cyc == CycLast) begin
      r.cyc = '0;
      r.sec = t.sec + 1'b1;
    end else begin
      r.cyc = t.cyc + 1'b1;
    end
    return r;
  endfunction

  always_comb begin
    nxt   = cur_q;
    bnd_d = 1'b0;
    if (en_i) begin
      if (load_i) begin
        nxt   = stamp_i;
        bnd_d = (stamp_i.cyc != cur_q.cyc);
      end else if (ext_sel_i) begin
        if (ext_rise_i) begin
          nxt   = next_cycle(cur_q);
          bnd_d = 1'b1;
        end else if (tick_i && cur_q.off != OffLast) begin
          nxt.off = cur_q.off + 1'b1;
        end
      end else if (tick_i) begin
        if (cur_q.off == OffLast) begin
          nxt   = next_cycle(cur_q);
          bnd_d = 1'b1;
        end else begin
          nxt.off = cur_q.off + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      bnd_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      cur_q <= nxt;
      bnd_q <= bnd_d;
      req_q <= bnd_d & master_i;
    end
  end

  assign time_o = cur_q;
  assign bnd_o  = bnd_q;
  assign req_o  = req_q;
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
  import cyc_timer_pkg::*;
#(
  parameter int OFF_LAST    = 3071,
  parameter int CYC_LAST    = 7999,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              master_i,
  input  logic              ext_sel_i,
  input  logic              cyc_ext_i,
  input  logic              rx_valid_i,
  input  logic [TIME_W-1:0] rx_stamp_i,
  output logic [TIME_W-1:0] timer_o,
  output logic              cycle_clk_o,
  output logic              start_req_o,
  output logic              boundary_o
);
  localparam int HALF = (OFF_LAST + 1) / 2;

  logic      tick, ext_rise, load;
  cyc_time_t cur;

  assign load = rx_valid_i & ~master_i;

  cyc_tick_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (enable_i),
    .tick_o (tick)
  );

  cyc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (cyc_ext_i),
    .rise_o (ext_rise)
  );

  cyc_count_chain #(.OFF_LAST(OFF_LAST), .CYC_LAST(CYC_LAST)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (enable_i),
    .tick_i     (tick),
    .ext_sel_i  (ext_sel_i),
    .ext_rise_i (ext_rise),
    .master_i   (master_i),
    .load_i     (load),
    .stamp_i    (cyc_time_t'(rx_stamp_i)),
    .time_o     (cur),
    .bnd_o      (boundary_o),
    .req_o      (start_req_o)
  );

  assign timer_o     = cur;
  assign cycle_clk_o = (cur.off < OFF_W'(HALF));
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
  parameter int OFF_LAST = 3071
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic        master_i,
  input logic        rx_valid_i,
  input logic [31:0] rx_stamp_i,
  input logic [31:0] timer_o,
  input logic        start_req_o,
  input logic        boundary_o
);
  p_off_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_o[11:0] <= 12'(OFF_LAST));

  p_bnd_off_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_o && !$past(rx_valid_i && !master_i)) |-> timer_o[11:0] == 12'd0);

  p_hold_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |-> ($stable(timer_o) && !boundary_o && !start_req_o));

  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rx_valid_i && !master_i && enable_i) |-> timer_o == $past(rx_stamp_i));

  p_req_master_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |-> (boundary_o && $past(master_i)));
endmodule

bind cyc_timer cyc_timer_chk #(.OFF_LAST(OFF_LAST)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .master_i    (master_i),
  .rx_valid_i  (rx_valid_i),
  .rx_stamp_i  (rx_stamp_i),
  .timer_o     (timer_o),
  .start_req_o (start_req_o),
  .boundary_o  (boundary_o)
);

// File: tb/cyc_timer_tb.sv
module cyc_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0, master_i = 1'b0, ext_sel_i = 1'b0, cyc_ext_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [31:0] rx_stamp_i = '0;
  logic [31:0] timer_o;
  logic        cycle_clk_o, start_req_o, boundary_o;

  int n_run = 0, n_fail = 0;
  int nb, nr;

  always #10 clk_i = ~clk_i;

  cyc_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .master_i(master_i),
    .ext_sel_i(ext_sel_i), .cyc_ext_i(cyc_ext_i), .rx_valid_i(rx_valid_i),
    .rx_stamp_i(rx_stamp_i), .timer_o(timer_o), .cycle_clk_o(cycle_clk_o),
    .start_req_o(start_req_o), .boundary_o(boundary_o)
  );

  function automatic logic [31:0] mk(int sec, int cyc, int off);
    return {7'(sec), 13'(cyc), 12'(off)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // run n clocks, counting boundary and request pulses
  task automatic run_count(int n, output int b, output int r);
    b = 0; r = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (boundary_o) b++;
      if (start_req_o) r++;
      if (start_req_o && !boundary_o) chk("R7 req without boundary", 32'd1, 32'd0);
    end
  endtask

  task automatic load(logic [31:0] s);
    rx_valid_i = 1'b1; rx_stamp_i = s;
    step(1);
    rx_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    step(3);
    chk("R1 timer", timer_o, 32'd0);
    chk("R1 boundary", {31'd0, boundary_o}, 32'd0);
    chk("R1 req", {31'd0, start_req_o}, 32'd0);
    rst_ni = 1'b1;
    step(2);
  endtask

  task automatic t_count;
    enable_i = 1'b1;
    run_count(10, nb, nr);
    chk("R2 R4 offset after 10 clocks", timer_o, mk(0, 0, 5));
    chk("R2 no boundary mid cycle", nb, 0);
  endtask

  task automatic t_reload;
    load(mk(2, 20, 5));
    chk("R6 load exact", timer_o, mk(2, 20, 5));
    chk("R6 boundary on new cycle", {31'd0, boundary_o}, 32'd1);
    load(mk(2, 20, 900));
    chk("R6 back-to-back load exact", timer_o, mk(2, 20, 900));
    chk("R6 no boundary same cycle", {31'd0, boundary_o}, 32'd0);
  endtask

  task automatic t_wrap;
    load(mk(3, 7999, 3070));
    run_count(4, nb, nr);
    chk("R2 R3 cycle wrap", timer_o, mk(4, 0, 0));
    chk("R2 one boundary", nb, 1);
    chk("R7 no req as slave", nr, 0);
    load(mk(127, 7999, 3071));
    run_count(4, nb, nr);
    chk("R3 seconds wrap", timer_o, mk(0, 0, 1));
    chk("R3 one boundary", nb, 1);
  endtask

  task automatic t_disable;
    logic [31:0] t0;
    enable_i = 1'b0;
    step(1);
    t0 = timer_o;
    run_count(3, nb, nr);
    rx_valid_i = 1'b1; rx_stamp_i = mk(9, 99, 99);
    step(1);
    rx_valid_i = 1'b0;
    chk("R5 load ignored", timer_o, t0);
    load(mk(1, 2, 3071));
    run_count(6, nb, nr);
    chk("R5 timer held", timer_o, t0);
    chk("R5 no boundary", nb, 0);
    enable_i = 1'b1;
  endtask

  task automatic t_master;
    load(mk(1, 10, 3060));
    master_i = 1'b1; rx_valid_i = 1'b1; rx_stamp_i = mk(9, 9, 9);
    step(1);
    rx_valid_i = 1'b0;
    chk("R7 stamp ignored as master", {19'd0, timer_o[24:12]}, 32'd10);
    run_count(29, nb, nr);
    chk("R7 timer after master run", timer_o, mk(1, 11, 3));
    chk("R7 one boundary", nb, 1);
    chk("R7 one request", nr, 1);
    master_i = 1'b0;
  endtask

  task automatic t_ext;
    ext_sel_i = 1'b1;
    load(mk(5, 7999, 100));
    cyc_ext_i = 1'b1;
    step(2);
    chk("R8 no advance before sync", {19'd0, timer_o[24:12]}, 32'd7999);
    step(1);
    chk("R8 R3 forced cycle", timer_o, mk(6, 0, 0));
    chk("R8 boundary", {31'd0, boundary_o}, 32'd1);
    run_count(6, nb, nr);
    chk("R8 level gives no boundary", nb, 0);
    chk("R8 offset runs", timer_o, mk(6, 0, 3));
    cyc_ext_i = 1'b0;
    load(mk(6, 0, 3069));
    run_count(10, nb, nr);
    chk("R8 offset saturates", timer_o, mk(6, 0, 3071));
    chk("R8 no wrap boundary", nb, 0);
    cyc_ext_i = 1'b1;
    step(3);
    chk("R8 second edge", timer_o, mk(6, 1, 0));
    cyc_ext_i = 1'b0;
    ext_sel_i = 1'b0;
  endtask

  task automatic t_cycle_clk;
    load(mk(0, 0, 1534));
    chk("R9 high below half", {31'd0, cycle_clk_o}, 32'd1);
    step(8);
    chk("R9 offset", timer_o, mk(0, 0, 1538));
    chk("R9 low above half", {31'd0, cycle_clk_o}, 32'd0);
  endtask

  initial begin
    step(1);
    t_reset();
    t_count();
    t_reload();
    t_wrap();
    t_disable();
    t_master();
    t_ext();
    t_cycle_clk();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule